// File: doc/BRIEF.md
# Time-Gated Input Delivery Queue

This block sits on the trailing side of a redundant processor pair whose two members run the same instruction stream, with the trailing member a fixed number of cycles behind the leading one. The leading side records each external input it receives and the timestamp at which it arrived. It then forwards both as a coordination message. This queue takes those messages, holds each one until the trailing side's local timestamp reaches the matching point, and then presents the payload to the trailing core. The trailing core therefore sees every input at the same logical time as its partner did.

Messages may arrive early, out of order, or with too little slack. The queue keeps its entries sorted by delivery deadline, so it always releases the earliest one first. It raises a one-cycle slowdown request when a message arrives close to its deadline, so that an external clock controller can rebuild the lag. A message that arrives when its deadline has already been reached cannot be delivered in lockstep. Such a message is dropped and latches a sticky error flag.

Top module: `timed_delivery_queue`

## Requirements
- R1: An accepted message's deadline is its carried timestamp plus LAG (default 8). Its payload appears on `outData` with `outValid` high in the cycle where `localTs` equals that deadline, and never earlier. The combinational output is consumed at the next clock edge.
- R2: Held messages are released in ascending deadline order, whatever order they arrived in.
- R3: Messages that share a deadline are released on consecutive cycles in arrival order. Any message queued behind them is released right after, with no gap. `busy` is high in every release cycle where the released deadline is already past, or where the next queued entry has the same deadline. It is low otherwise.
- R4: Slack is the deadline minus `localTs` at acceptance. `slowReq` is high for exactly the cycle after a message is accepted with slack below MARGIN (default 4), and low after any other cycle. Slack 3 raises it and slack 4 does not.
- R5: A message accepted with slack of zero or less is dropped and never delivered. It sets `lockErr`, which stays high until reset.
- R6: The queue holds DEPTH (default 16) messages. `inReady` is low while all are occupied. A message offered while `inReady` is low is not taken and never delivered.
- R7: Timestamps are compared modulo 2^TS_W, so ordering and release timing stay correct when deadlines or `localTs` wrap through zero. This holds while all live deadlines lie within half the timestamp range of `localTs`.
- R8: After reset nothing is held: `outValid`, `busy`, `slowReq` and `lockErr` are low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| localTs | input | TS_W | Trailing side's local timestamp |
| inValid | input | 1 | Incoming coordination message present |
| inReady | output | 1 | Queue can take a message this cycle |
| inTs | input | TS_W | Timestamp at which the leading side saw the input |
| inData | input | DATA_W | Input payload |
| outValid | output | 1 | Payload is delivered this cycle |
| outData | output | DATA_W | Delivered payload |
| busy | output | 1 | Release belongs to a tie or backlog burst |
| slowReq | output | 1 | Slack below margin seen on last accepted message |
| lockErr | output | 1 | Sticky: a message arrived past its deadline |

## Verification
The assertions check the following on every cycle:
- the held entries stay sorted by deadline and form a contiguous prefix;
- a full queue stays full unless it releases;
- the lockstep error never clears;
- a late arrival raises both flags;
- a release with a tied successor is followed by another release.

Only the bench's scenarios can show the timing and content of deliveries. These include the exact release cycle against `localTs`, the order under reversed arrivals, the busy pattern over a tie burst, the margin boundary between slack 3 and 4, a refused message while full, and release timing across the timestamp wrap.

// File: rtl/tdq_pkg.sv
`timescale 1ns/1ps
package tdq_pkg;
  typedef struct packed {
    logic push;  // insert the incoming message at its sorted place
    logic pop;   // remove the head entry (delivered this cycle)
  } tdqStrobe_t;
endpackage

// File: rtl/tdq_store.sv
`timescale 1ns/1ps
module tdq_store
  import tdq_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tdqStrobe_t        strb,
  input  logic [TS_W-1:0]   newDl,
  input  logic [DATA_W-1:0] newData,
  output logic [TS_W-1:0]   headDl,
  output logic [DATA_W-1:0] headData,
  output logic [TS_W-1:0]   secondDl,
  output logic [1:0]        headVld,
  output logic              full
);
  localparam int PW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]             vld;
  logic [DEPTH-1:0][TS_W-1:0]   dlQ;
  logic [DEPTH-1:0][DATA_W-1:0] dataQ;

  logic [DEPTH-1:0]             leMask;
  logic [DEPTH-1:0]             shV, nxV;
  logic [DEPTH-1:0][TS_W-1:0]   shDl, nxDl;
  logic [DEPTH-1:0][DATA_W-1:0] shData, nxData;
  logic [PW-1:0]                pos, posEff;

  // entries whose deadline is not after the new one stay ahead of it
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [TS_W-1:0] diff;
    assign diff      = dlQ[i] - newDl;
    assign leMask[i] = vld[i] && (diff[TS_W-1] || diff == '0);
  end

  always_comb begin
    pos = '0;
    for (int i = 0; i < DEPTH; i++) pos = pos + PW'(leMask[i]);
  end
  assign posEff = strb.pop ? pos - PW'(1) : pos;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i < DEPTH - 1) begin : g_mid
      assign shV[i]    = strb.pop ? vld[i+1]   : vld[i];
      assign shDl[i]   = strb.pop ? dlQ[i+1]   : dlQ[i];
      assign shData[i] = strb.pop ? dataQ[i+1] : dataQ[i];
    end else begin : g_last
      assign shV[i]    = strb.pop ? 1'b0 : vld[i];
      assign shDl[i]   = dlQ[i];
      assign shData[i] = dataQ[i];
    end

    if (i == 0) begin : g_first
      always_comb begin
        if (strb.push && posEff == '0) begin
          nxV[i] = 1'b1; nxDl[i] = newDl; nxData[i] = newData;
        end else begin
          nxV[i] = shV[i]; nxDl[i] = shDl[i]; nxData[i] = shData[i];
        end
      end
    end else begin : g_rest
      always_comb begin
        if (strb.push && PW'(i) == posEff) begin
          nxV[i] = 1'b1; nxDl[i] = newDl; nxData[i] = newData;
        end else if (strb.push && PW'(i) > posEff) begin
          nxV[i] = shV[i-1]; nxDl[i] = shDl[i-1]; nxData[i] = shData[i-1];
        end else begin
          nxV[i] = shV[i]; nxDl[i] = shDl[i]; nxData[i] = shData[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= '0;
      dlQ   <= '0;
      dataQ <= '0;
    end else begin
      vld   <= nxV;
      dlQ   <= nxDl;
      dataQ <= nxData;
    end
  end

  assign headDl   = dlQ[0];
  assign headData = dataQ[0];
  assign secondDl = dlQ[1];
  assign headVld  = vld[1:0];
  assign full     = vld[DEPTH-1];

  for (genvar i = 0; i < DEPTH - 1; i++) begin : g_chk
    AST_SORTED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      vld[i+1] |-> !($signed(dlQ[i+1] - dlQ[i]) < 0)); // R2
  end
  AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vld + 1'b1)); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    full && !strb.pop |=> full); // R6
endmodule

// File: rtl/tdq_ctrl.sv
`timescale 1ns/1ps
module tdq_ctrl
  import tdq_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int LAG    = 8,
  parameter int MARGIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] localTs,
  input  logic            inValid,
  input  logic [TS_W-1:0] inTs,
  input  logic [TS_W-1:0] headDl,
  input  logic [TS_W-1:0] secondDl,
  input  logic [1:0]      headVld,
  input  logic            full,
  output tdqStrobe_t      strb,
  output logic [TS_W-1:0] newDl,
  output logic            inReady,
  output logic            outValid,
  output logic            busy,
  output logic            slowReq,
  output logic            lockErr
);
  localparam logic [TS_W-1:0] LagV    = TS_W'(LAG);
  localparam logic [TS_W-1:0] MarginV = TS_W'(MARGIN);

  logic [TS_W-1:0] slackNew, headSlack;
  logic accept, onTime, shortSlack, headDue, tie;

  assign newDl      = inTs + LagV;
  assign slackNew   = newDl - localTs;
  assign headSlack  = headDl - localTs;

  assign inReady    = !full;
  assign accept     = inValid && inReady;
  assign onTime     = !slackNew[TS_W-1] && slackNew != '0;
  assign shortSlack = $signed(slackNew) < $signed(MarginV);

  assign headDue    = headVld[0] && (headSlack[TS_W-1] || headSlack == '0);
  assign tie        = headVld[1] && secondDl == headDl;

  assign strb.push  = accept && onTime;
  assign strb.pop   = headDue;
  assign outValid   = headDue;
  assign busy       = headDue && (headSlack != '0 || tie);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slowReq <= 1'b0;
      lockErr <= 1'b0;
    end else begin
      slowReq <= accept && shortSlack;
      lockErr <= lockErr || (accept && !onTime);
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lockErr |=> lockErr); // R5
  AST_LATE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && !onTime |=> lockErr && slowReq); // R5
  AST_TIE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && tie |=> outValid); // R3
endmodule

// File: rtl/timed_delivery_queue.sv
`timescale 1ns/1ps
module timed_delivery_queue
  import tdq_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int LAG    = 8,
  parameter int MARGIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   localTs,
  input  logic              inValid,
  output logic              inReady,
  input  logic [TS_W-1:0]   inTs,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              busy,
  output logic              slowReq,
  output logic              lockErr
);
  tdqStrobe_t      strb;
  logic [TS_W-1:0] newDl, headDl, secondDl;
  logic [1:0]      headVld;
  logic            full;

  tdq_ctrl #(.TS_W(TS_W), .LAG(LAG), .MARGIN(MARGIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .localTs(localTs), .inValid(inValid), .inTs(inTs),
    .headDl(headDl), .secondDl(secondDl), .headVld(headVld), .full(full),
    .strb(strb), .newDl(newDl), .inReady(inReady), .outValid(outValid),
    .busy(busy), .slowReq(slowReq), .lockErr(lockErr)
  );

  tdq_store #(.TS_W(TS_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .strb(strb), .newDl(newDl), .newData(inData),
    .headDl(headDl), .headData(outData), .secondDl(secondDl),
    .headVld(headVld), .full(full)
  );
endmodule

// File: tb/sim_timed_delivery_queue.sv
`timescale 1ns/1ps
module sim_timed_delivery_queue;
  localparam int LAG = 8;
  localparam int MARGIN = 4;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] localTs = 32'hFFFF_F800;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inTs = '0;
  logic [15:0] inData = '0;
  logic        outValid, busy, slowReq, lockErr;
  logic [15:0] outData;

  int nChk = 0, nFail = 0, cyc = 0;
  logic [47:0] sb[$];
  logic [31:0] lastRel = '0;
  logic        haveRel = 1'b0;
  logic        expLock = 1'b0;

  timed_delivery_queue u0 (
    .clk(clk), .rst_n(rst_n), .localTs(localTs), .inValid(inValid), .inReady(inReady),
    .inTs(inTs), .inData(inData), .outValid(outValid), .outData(outData),
    .busy(busy), .slowReq(slowReq), .lockErr(lockErr)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    #1 localTs <= localTs + 32'd1;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: offer one message; absolute deadline or slack relative to now
  task automatic send(input logic isAbs, input logic [31:0] v, input logic [15:0] d,
                      output logic taken);
    logic [31:0] dl, slack;
    int idx;
    @(negedge clk); #2;
    dl = isAbs ? v : localTs + v;
    slack = dl - localTs;
    inTs = dl - 32'(LAG);
    inData = d;
    inValid = 1'b1;
    taken = inReady;
    @(posedge clk); #1;
    inValid = 1'b0;
    if (taken) begin
      check("R4 slowReq after accept", slowReq, 64'($signed(slack) < MARGIN));
      if ($signed(slack) > 0) begin
        idx = sb.size();
        for (int k = 0; k < sb.size(); k++)
          if ($signed(sb[k][47:16] - dl) > 0) begin idx = k; break; end
        sb.insert(idx, {dl, d});
      end else begin
        expLock = 1'b1;
      end
      check("R5 lockErr state", lockErr, 64'(expLock));
    end
  endtask

  // monitor: scoreboard compare, sampled with the timestamp the next edge uses
  always @(negedge clk) begin
    logic [31:0] fDl, expRel;
    logic        expBusy;
    #3;
    if (rst_n) begin
      if (sb.size() > 0) begin
        fDl = sb[0][47:16];
        expRel = fDl;
        if (haveRel && $signed((lastRel + 32'd1) - fDl) > 0) expRel = lastRel + 32'd1;
        if (localTs == expRel) begin
          check("R1 R2 R7 release at deadline", outValid, 1);
          check("R2 release payload order", outData, sb[0][15:0]);
          expBusy = (localTs != fDl) || (sb.size() > 1 && sb[1][47:16] == fDl);
          check("R3 busy on release", busy, 64'(expBusy));
          void'(sb.pop_front());
          lastRel = localTs;
          haveRel = 1'b1;
        end else begin
          check("R1 hold before deadline", outValid, 0);
        end
      end else if (outValid) begin
        check("R5 R6 unexpected release", 1, 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 200000) begin
      nFail++;
      $display("FAIL R1 watchdog expired actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic        tk;
    logic [31:0] base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    check("R8 reset outValid", outValid, 0);
    check("R8 reset inReady", inReady, 1);
    check("R8 reset busy", busy, 0);
    check("R8 reset slowReq", slowReq, 0);
    check("R8 reset lockErr", lockErr, 0);

    // R1: in order, ample slack
    send(0, 32'd20, 16'hA001, tk);
    send(0, 32'd25, 16'hA002, tk);
    idle(30);

    // R2: reversed arrival
    send(0, 32'd30, 16'hB001, tk);
    send(0, 32'd22, 16'hB002, tk);
    send(0, 32'd26, 16'hB003, tk);
    idle(35);

    // R3: three tied deadlines and one right after
    @(negedge clk); #2; base = localTs + 32'd20;
    send(1, base, 16'hC001, tk);
    send(1, base, 16'hC002, tk);
    send(1, base + 32'd1, 16'hC004, tk);
    send(1, base, 16'hC003, tk);
    idle(30);

    // R4: margin boundary
    send(0, 32'd4, 16'hD004, tk);
    idle(8);
    send(0, 32'd3, 16'hD003, tk);
    idle(8);
    send(0, 32'd1, 16'hD001, tk);
    idle(8);
    check("R4 slowReq clears", slowReq, 0);

    // R5: late arrivals dropped, error sticky
    send(0, 32'd0, 16'hE000, tk);
    idle(4);
    send(0, 32'hFFFF_FFFD, 16'hE001, tk);
    idle(10);
    check("R5 lockErr sticky", lockErr, 1);
    send(0, 32'd12, 16'hE002, tk);
    idle(20);

    // R6: fill all entries, then a refused offer
    for (int k = 0; k < DEPTH; k++) send(0, 32'd200, 16'hF000 + 16'(k), tk);
    @(negedge clk); #3;
    check("R6 inReady low when full", inReady, 0);
    send(0, 32'd30, 16'hBEEF, tk);
    check("R6 offer refused when full", tk, 0);
    idle(240);
    check("R6 queue drained", 64'(sb.size()), 0);
    check("R6 inReady back", inReady, 1);

    // R7: deadlines straddle the wrap of the timestamp
    while ($signed(localTs - 32'hFFFF_FFF0) < 0) @(negedge clk);
    send(0, 32'd24, 16'h7001, tk);
    send(0, 32'd14, 16'h7002, tk);
    send(0, 32'd6, 16'h7003, tk);
    idle(40);
    check("R7 wrap releases complete", 64'(sb.size()), 0);
    check("R7 wrap localTs crossed zero", 64'(localTs < 32'h1000), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule